// File: doc/BRIEF.md
# Program-Step Data Capture Unit

This block watches a signal-processing core as it steps through its program. Each of eight capture channels holds a control word. The word names one program step and one of four internal datapath taps: the multiplier X operand, the multiplier Y operand, the MAC result or the accumulator feedback. When the core's program counter reaches that step, the channel copies the chosen tap into its capture register. Firmware uses this to watch signal levels or dynamics-processor activity without stopping the core.

Six channels can be read over the control port, one full word per read. The other two channels feed a shift register. Each frame it is loaded with both of their values, and it is then shifted out MSB-first on a serial pin. The pin is active only while the serial capture enable is set. A frame-start pulse from the core marks each pass through the program. A channel captures at most once between two such pulses, so every value it holds belongs to a single frame.

Top module: `dcap_unit`

## Requirements
- R1: A control word is 13 bits. Bits 12:2 hold the program step to match and bits 1:0 hold the tap select. It is written with `cfg_we` to the channel numbered by `cfg_sel`, where 0 to 5 are the host channels and 6 and 7 are the serial channels. After reset every control word is zero.
- R2: Tap select 00 picks the multiplier X input, 01 the multiplier Y input, 10 the MAC output and 11 the accumulator feedback.
- R3: On a clock edge where `pc` equals the channel's step, the channel's capture register takes the selected tap. The value is visible from the next cycle. At any other edge the register keeps its value.
- R4: Once a channel has captured in a frame, later matches are ignored until `frame_start` is high. A match in the same cycle as `frame_start` does capture.
- R5: A programmed step from 1536 to 2047 never triggers a capture.
- R6: With `rd_en` high and `rd_sel` from 0 to 5, `rd_data` shows that channel's whole capture word from the next cycle on. While `rd_en` is low, `rd_data` holds its value.
- R7: A read with `rd_sel` of 6 or 7 returns zero, because those channels are not host-readable.
- R8: `ser_load` loads a 2×DW shift register with channel 6 in the upper half and channel 7 in the lower half. This takes priority over `ser_shift`. Each `ser_shift` moves the register one place toward the MSB and fills the bottom with zero. While enabled, `ser_dout` shows the register's MSB.
- R9: `ser_dout` is low whenever `ser_en` is low. `ser_en` is bit 14 of the serial output control register.
- R10: After a synchronous active-low reset, all capture registers, `rd_data` and the shift register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc | input | 11 | Core program counter |
| frame_start | input | 1 | Pulse at the first step of each frame |
| tap_mul_x | input | DW | Multiplier X operand |
| tap_mul_y | input | DW | Multiplier Y operand |
| tap_mac | input | DW | MAC result |
| tap_acc | input | DW | Accumulator feedback |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 3 | Channel addressed by the write |
| cfg_word | input | 13 | Control word: step in 12:2, tap in 1:0 |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 3 | Channel addressed by the read |
| rd_data | output | DW | Registered read result |
| ser_en | input | 1 | Serial capture output enable |
| ser_load | input | 1 | Load the shift register from channels 6 and 7 |
| ser_shift | input | 1 | Shift the register by one bit |
| ser_dout | output | 1 | Serial capture output |

## Verification
The embedded properties assume that `frame_start` arrives once per pass through the program. They also assume that control writes and the serial strobes are single-cycle and synchronous to `clk`. The bench drives the program counter as a program loop that raises `frame_start` with step 0. It also takes out-of-frame detours: it revisits a step within a frame and jumps to a step beyond 1535. The serial strobes are only ever issued as one load followed by a run of shifts, in both enable states.

// File: rtl/dcap_pkg.sv
// Package: shared widths, limits and types of the data capture unit.
// Assumes an 11-bit program counter and a 13-bit packed control word.
package dcap_pkg;
    localparam int PC_W     = 11;
    localparam int TAP_W    = 2;
    localparam int CTRL_W   = PC_W + TAP_W;
    localparam int STEP_LIM = 1535;

    typedef enum logic [TAP_W-1:0] {
        TAP_MUL_X = 2'b00,
        TAP_MUL_Y = 2'b01,
        TAP_MAC   = 2'b10,
        TAP_ACC   = 2'b11
    } tap_e;

    typedef struct packed {
        logic [PC_W-1:0] step;
        tap_e            tap;
    } ctrl_t;
endpackage

// File: rtl/dcap_channel.sv
// One capture channel: stores its control word, compares the program
// counter against the programmed step and latches the selected tap once
// per frame. Assumes frame_start pulses once per program pass.
module dcap_channel
    import dcap_pkg::*;
#(
    parameter int DW = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_word,
    input  logic [PC_W-1:0]   pc,
    input  logic              frame_start,
    input  logic [DW-1:0]     tap_mul_x,
    input  logic [DW-1:0]     tap_mul_y,
    input  logic [DW-1:0]     tap_mac,
    input  logic [DW-1:0]     tap_acc,
    output logic [DW-1:0]     cap_q
);
    localparam logic [PC_W-1:0] LIM = PC_W'(STEP_LIM);

    ctrl_t         cfg_q;
    logic          done_q;
    logic          hit;
    logic [DW-1:0] tap_mux;

    // Holds the control word written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= ctrl_t'(cfg_word);
    end

    // Picks the datapath tap named by the control word.
    always_comb begin
        unique case (cfg_q.tap)
            TAP_MUL_X: tap_mux = tap_mul_x;
            TAP_MUL_Y: tap_mux = tap_mul_y;
            TAP_MAC:   tap_mux = tap_mac;
            default:   tap_mux = tap_acc;
        endcase
    end

    // Trigger: in-range step, exact match, not yet taken this frame.
    always_comb begin
        hit = (pc == cfg_q.step) && (cfg_q.step <= LIM) && (!done_q || frame_start);
    end

    // Remembers whether this frame's capture has happened.
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= 1'b0;
        else if (frame_start) done_q <= hit;
        else if (hit)         done_q <= 1'b1;
    end

    // Latches the selected tap on a trigger, whole word at once.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (hit) cap_q <= tap_mux;
    end

    assert_once_per_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !frame_start) |=> $stable(cap_q));

    assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.step > LIM) |=> $stable(cap_q));

    assert_mac_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_q.tap == TAP_MAC) |=> (cap_q == $past(tap_mac)));

    assert_no_match_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != cfg_q.step) |=> $stable(cap_q));
endmodule

// File: rtl/dcap_readport.sv
// Host read port: registers one whole capture word per read so a read
// never mixes bits of two captures. Channels at NHOST and above read zero.
module dcap_readport #(
    parameter int DW    = 28,
    parameter int NCH   = 8,
    parameter int NHOST = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [$clog2(NCH)-1:0] rd_sel,
    input  logic [NCH*DW-1:0]      cap_flat,
    output logic [DW-1:0]          rd_data
);
    localparam int SEL_W = $clog2(NCH);

    logic [DW-1:0] rd_mux;

    // Selects the addressed host channel, zero for serial-only channels.
    always_comb begin
        if (rd_sel < SEL_W'(NHOST)) rd_mux = cap_flat[int'(rd_sel)*DW +: DW];
        else                        rd_mux = '0;
    end

    // Captures the read result on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_serial_unreadable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel >= SEL_W'(NHOST)) |=> (rd_data == '0));
endmodule

// File: rtl/dcap_serializer.sv
// Serial capture output: parallel-loads the serial channels and shifts
// them MSB-first. Assumes load and shift are single-cycle strobes.
module dcap_serializer #(
    parameter int DW   = 28,
    parameter int NSER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             ser_load,
    input  logic             ser_shift,
    input  logic [NSER*DW-1:0] par_in,
    output logic             ser_dout
);
    localparam int SR_W = NSER * DW;

    logic [SR_W-1:0] sr_q;

    // Loads or shifts the output register; load wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '0;
        else if (ser_load)  sr_q <= par_in;
        else if (ser_shift) sr_q <= {sr_q[SR_W-2:0], 1'b0};
    end

    // Drives the pin from the MSB only while enabled.
    always_comb begin
        ser_dout = ser_en & sr_q[SR_W-1];
    end

    assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_shift && !ser_load) |=> (sr_q[0] == 1'b0));
endmodule

// File: rtl/dcap_unit.sv
// Top of the data capture unit: eight channels, a host read port over the
// first NHOST, and a serializer over the remaining NSER channels.
// Assumes pc, taps and strobes are synchronous to clk.
module dcap_unit
    import dcap_pkg::*;
#(
    parameter int DW    = 28,
    parameter int NHOST = 6,
    parameter int NSER  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [10:0]            pc,
    input  logic                   frame_start,
    input  logic [DW-1:0]          tap_mul_x,
    input  logic [DW-1:0]          tap_mul_y,
    input  logic [DW-1:0]          tap_mac,
    input  logic [DW-1:0]          tap_acc,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_sel,
    input  logic [12:0]            cfg_word,
    input  logic                   rd_en,
    input  logic [2:0]             rd_sel,
    output logic [DW-1:0]          rd_data,
    input  logic                   ser_en,
    input  logic                   ser_load,
    input  logic                   ser_shift,
    output logic                   ser_dout
);
    localparam int NCH   = NHOST + NSER;
    localparam int SEL_W = $clog2(NCH);

    logic [NCH*DW-1:0]  cap_flat;
    logic [NSER*DW-1:0] ser_par;

    // One channel per capture slot, each with its own write decode.
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic we_k;
        always_comb we_k = cfg_we && (cfg_sel == SEL_W'(k));
        dcap_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(we_k), .cfg_word(cfg_word),
            .pc(pc), .frame_start(frame_start),
            .tap_mul_x(tap_mul_x), .tap_mul_y(tap_mul_y),
            .tap_mac(tap_mac), .tap_acc(tap_acc),
            .cap_q(cap_flat[k*DW +: DW])
        );
    end

    // First serial channel sits in the upper part of the shift register.
    for (genvar j = 0; j < NSER; j++) begin : g_ser
        always_comb ser_par[(NSER-1-j)*DW +: DW] = cap_flat[(NHOST+j)*DW +: DW];
    end

    dcap_readport #(.DW(DW), .NCH(NCH), .NHOST(NHOST)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_sel(rd_sel),
        .cap_flat(cap_flat), .rd_data(rd_data)
    );

    dcap_serializer #(.DW(DW), .NSER(NSER)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .ser_en(ser_en), .ser_load(ser_load), .ser_shift(ser_shift),
        .par_in(ser_par), .ser_dout(ser_dout)
    );

    assert_load_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load && ser_en) |=> (!ser_en || ser_dout == $past(cap_flat[NHOST*DW + DW-1])));

    assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && $past(!ser_en)) |-> !ser_dout);
endmodule

// File: tb/dcap_unit_bench.sv
module dcap_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 28;
    localparam int NHOST = 6;
    localparam int NCH   = 8;
    localparam int LIM   = 1535;
    localparam int NSTEP = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [10:0] pc = '0;
    logic frame_start = 1'b0;
    logic [DW-1:0] tap_mul_x = '0, tap_mul_y = '0, tap_mac = '0, tap_acc = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [12:0] cfg_word = '0;
    logic rd_en = 1'b0;
    logic [2:0] rd_sel = '0;
    logic [DW-1:0] rd_data;
    logic ser_en = 1'b0, ser_load = 1'b0, ser_shift = 1'b0;
    logic ser_dout;

    dcap_unit #(.DW(DW), .NHOST(NHOST), .NSER(2)) u_dcap_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit done_flag = 0;

    // reference model state
    logic [DW-1:0]   m_cap [NCH];
    logic [12:0]     m_cfg [NCH];
    bit              m_done [NCH];
    logic [2*DW-1:0] m_sr;
    logic [DW-1:0]   m_rd;

    function automatic logic [DW-1:0] tap_val(int kind, int salt, int pcv);
        return DW'(kind * 28'h0100000 + salt * 28'h0001000 + pcv);
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // advance model and design by one clock, then compare outputs
    task automatic cycle(string tag);
        logic [DW-1:0] old_cap [NCH];
        int step, tsel;
        bit hit;
        logic [DW-1:0] sel_tap;
        for (int k = 0; k < NCH; k++) old_cap[k] = m_cap[k];
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                m_cap[k] = '0; m_cfg[k] = '0; m_done[k] = 0;
            end
            m_sr = '0; m_rd = '0;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                step = int'(m_cfg[k][12:2]);
                tsel = int'(m_cfg[k][1:0]);
                hit = (int'(pc) == step) && (step <= LIM) && (!m_done[k] || frame_start);
                sel_tap = (tsel == 0) ? tap_mul_x : (tsel == 1) ? tap_mul_y :
                          (tsel == 2) ? tap_mac : tap_acc;
                if (hit) m_cap[k] = sel_tap;
                if (frame_start) m_done[k] = hit;
                else if (hit)    m_done[k] = 1;
            end
            if (cfg_we) m_cfg[cfg_sel] = cfg_word;
            if (rd_en) m_rd = (int'(rd_sel) < NHOST) ? old_cap[rd_sel] : '0;
            if (ser_load)       m_sr = {old_cap[6], old_cap[7]};
            else if (ser_shift) m_sr = {m_sr[2*DW-2:0], 1'b0};
        end
        @(posedge clk);
        #1;
        check(tag, "rd_data", rd_data, m_rd);
        check(tag, "ser_dout", DW'(ser_dout), DW'(ser_en & m_sr[2*DW-1]));
    endtask

    task automatic set_taps(int salt, int pcv);
        tap_mul_x = tap_val(0, salt, pcv);
        tap_mul_y = tap_val(1, salt, pcv);
        tap_mac   = tap_val(2, salt, pcv);
        tap_acc   = tap_val(3, salt, pcv);
    endtask

    task automatic run_frame(int salt, string tag);
        for (int p = 0; p < NSTEP; p++) begin
            pc = 11'(p);
            frame_start = (p == 0);
            set_taps(salt, p);
            rd_en = 1'b1;
            rd_sel = 3'(p % 8);
            cycle(tag);
        end
        frame_start = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic read_ch(int ch, logic [DW-1:0] exp, string tag);
        rd_en = 1'b1; rd_sel = 3'(ch); pc = 11'd2000;
        cycle(tag);
        rd_en = 1'b0;
        check(tag, "directed read", rd_data, exp);
    endtask

    initial begin
        // R10: reset state
        rst_n = 1'b0;
        ser_en = 1'b1;
        cycle("R10"); cycle("R10");
        check("R10", "rd_data after reset", rd_data, '0);
        check("R10", "ser_dout after reset", DW'(ser_dout), '0);
        rst_n = 1'b1;

        // R1: program control words {step, tap}
        begin
            int steps [NCH] = '{5, 7, 3, 9, 1600, 0, 4, 6};
            int taps  [NCH] = '{0, 1, 2, 3, 0, 1, 2, 0};
            for (int k = 0; k < NCH; k++) begin
                cfg_we = 1'b1; cfg_sel = 3'(k);
                cfg_word = {11'(steps[k]), 2'(taps[k])};
                pc = 11'd2000;
                cycle("R1");
            end
            cfg_we = 1'b0;
        end

        // R2, R3: frames with distinct tap patterns
        for (int s = 1; s <= 6; s++) run_frame(s, "R2 R3");
        read_ch(2, tap_val(2, 6, 3), "R2");
        read_ch(3, tap_val(3, 6, 9), "R2");
        read_ch(1, tap_val(1, 6, 7), "R3");
        read_ch(5, tap_val(1, 6, 0), "R4");

        // R4: revisit step 5 within the same frame; ignored
        pc = 11'd5; set_taps(99, 5);
        cycle("R4");
        read_ch(0, tap_val(0, 6, 5), "R4");

        // R5: step beyond the limit never captures
        pc = 11'd1600; set_taps(77, 1600); frame_start = 1'b1;
        cycle("R5");
        frame_start = 1'b0;
        read_ch(4, '0, "R5");

        // R7: serial channels read as zero
        read_ch(6, '0, "R7");
        read_ch(7, '0, "R7");

        // R6: reads idle while captures change
        run_frame(8, "R6");
        for (int i = 0; i < 4; i++) begin
            rd_en = 1'b0; pc = 11'(i + 3); set_taps(9, i);
            cycle("R6");
        end
        read_ch(0, tap_val(0, 8, 5), "R6");

        // R8: load serial channels and shift out, enabled
        ser_en = 1'b1; ser_load = 1'b1;
        cycle("R8");
        ser_load = 1'b0;
        check("R8", "first serial bit", DW'(ser_dout), DW'(tap_val(2, 8, 4) >> (DW-1)));
        ser_shift = 1'b1;
        for (int i = 0; i < 2*DW + 2; i++) cycle("R8");
        ser_shift = 1'b0;

        // R9: disabled pin stays low through load and shifts
        run_frame(12, "R9");
        ser_en = 1'b0; ser_load = 1'b1;
        cycle("R9");
        ser_load = 1'b0; ser_shift = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cycle("R9");
            check("R9", "pin low", DW'(ser_dout), '0);
        end
        ser_shift = 1'b0;
        ser_en = 1'b1;
        cycle("R8");

        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            done_flag = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule